// File: doc/BRIEF.md
# Wormhole Fat-Tree Router Node

This block is a single switching node of a fat-tree on-chip network. It has a group of child ports that face the leaves and a group of parent ports that face the root. Each port carries 32-bit words with valid/ready flow control and a side-band tail flag. A packet is a run of words that ends with the word whose tail flag is set, and it may be of any length. The first word of a packet names the destination terminal.

Each input port has a small FIFO. When a head word reaches the front of its FIFO, the node decides where the packet goes. If the destination lies inside the subtree under this node, the packet goes down through the one child port that the address selects. If the destination lies outside, the packet goes up through whichever parent port is free, and the lowest-numbered free parent port is used. Once an output port is granted to a packet, it stays with that packet until the tail word has passed. While several inputs want the same output, they take turns in round-robin order.

The node's place in the tree is set by parameters: the tree level and the index of the subtree it covers. The same RTL therefore serves every node position.

Top module: `frt_router`

## Requirements
- R1: Each port carries a 32-bit data word and a tail flag. The first word of a packet holds the destination terminal address in bits [ADDR_W-1:0], 4 bits by default. Every word leaves the node unchanged, and every accepted packet is delivered.
- R2: A packet from a child input whose destination bits above the level field equal SUBTREE_ID (bits [3:2] equal 1 by default) leaves on child output number dest[CHILD_BITS*(LEVEL+1)-1 : CHILD_BITS*LEVEL], which is dest[1:0] by default.
- R3: A packet whose destination lies outside the subtree leaves on the lowest-index parent output that has no packet in flight. Port indices 0..NUM_CHILD-1 are children and NUM_CHILD..NUM_CHILD+NUM_PARENT-1 are parents, for inputs and outputs alike.
- R4: A packet that enters on a parent input always descends, to the child output its address selects.
- R5: An output carries the words of one packet in order, with no words from any other packet, from the head word through the tail word.
- R6: When several inputs request the same output, it is granted round-robin. A new grant is made only after the current packet's tail word has passed, so back-to-back contenders alternate.
- R7: Each input accepts up to FIFO_DEPTH (4) words while nothing drains it, then drops in_ready. It raises in_ready again once words leave.
- R8: While out_valid is high and out_ready is low, the output word and its tail flag stay unchanged until they are accepted.
- R9: During and right after reset, every out_valid is low and every in_ready is high.
- R10: Packets of any length, including a single word that is both head and tail, pass intact, with the tail flag only on the last word.
- R11: While every parent output is busy, a climbing packet waits in its FIFO and appears on no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | NP (6) | Per-input word valid |
| in_ready | output | NP (6) | Per-input FIFO has room |
| in_data | input | NP*32 (192) | Per-input data words, port i in bits [32*i+31:32*i] |
| in_last | input | NP (6) | Per-input tail flag |
| out_valid | output | NP (6) | Per-output word valid |
| out_ready | input | NP (6) | Per-output downstream can accept |
| out_data | output | NP*32 (192) | Per-output data words, same packing as in_data |
| out_last | output | NP (6) | Per-output tail flag |

## Verification
Four properties are checked on every cycle:
- A stalled output word stays stable.
- An output's owner stays fixed until a tail word is transferred.
- A parent output is never owned by a parent input.
- No input is bound to two outputs at once.

Some behaviours only the bench scenarios can show. These are:
- the choice of output for each address;
- the pick of the lowest free parent;
- alternation among contenders;
- the FIFO fill limit;
- a climbing packet waiting while every parent is busy;
- end-to-end delivery of packets of random length under random backpressure.

The bench checks each of these against a model built from the address rules.

// File: rtl/frt_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the fat-tree router: word width and the word
// format carried through the input FIFOs and output ports.
package frt_pkg;
    localparam int FLIT_W = 32;

    // One word on a link: tail marker above the data bits.
    typedef struct packed {
        logic              last;
        logic [FLIT_W-1:0] data;
    } flit_t;
endpackage

// File: rtl/frt_in_fifo.sv
`timescale 1ns/1ps
// Input FIFO of one router port.
// Holds DEPTH words. push_ready is high while there is room.
// head_word is valid whenever head_valid is high.
// Assumes: pop is only asserted together with head_valid.
module frt_in_fifo #(
    parameter int W     = 33,
    parameter int DEPTH = 4,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_valid,
    output logic         push_ready,
    input  logic [W-1:0] push_word,
    output logic         head_valid,
    output logic [W-1:0] head_word,
    input  logic         pop
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    // Advance a pointer with wrap at DEPTH.
    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign push_ready = (count != CW'(DEPTH));
    assign head_valid = (count != '0);
    assign head_word  = mem[rd_ptr];
    assign do_push    = push_valid && push_ready;
    assign do_pop     = pop && head_valid;

    // Store the incoming word at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_word;
    end

    // Maintain the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            if (do_push && !do_pop)      count <= count + CW'(1);
            else if (do_pop && !do_push) count <= count - CW'(1);
        end
    end
endmodule

// File: rtl/frt_route.sv
`timescale 1ns/1ps
// Route decision for one head word.
// "up" is set when the destination lies outside the subtree that this node covers.
// "child" gives the child port that the address field for this level selects.
// Inputs on the parent side never climb.
// The root node (no address bits above its level) never climbs.
module frt_route #(
    parameter int ADDR_W      = 4,
    parameter int CHILD_BITS  = 2,
    parameter int LEVEL       = 0,
    parameter int SUBTREE_ID  = 1,
    parameter bit FROM_PARENT = 1'b0,
    localparam int LO         = CHILD_BITS * LEVEL,
    localparam int HI_LSB     = CHILD_BITS * (LEVEL + 1)
) (
    input  logic [ADDR_W-1:0]     dest,
    output logic                  up,
    output logic [CHILD_BITS-1:0] child
);
    logic unused_addr_bits;
    assign unused_addr_bits = ^dest;

    // The child port index is the address field for this level.
    assign child = dest[LO +: CHILD_BITS];

    generate
        if (FROM_PARENT || HI_LSB >= ADDR_W) begin : g_down_only
            // Traffic from above, or the root: always descend.
            assign up = 1'b0;
        end else begin : g_compare
            // Climb when the upper address bits name another subtree.
            assign up = (dest[ADDR_W-1:HI_LSB] != (ADDR_W - HI_LSB)'(SUBTREE_ID));
        end
    endgenerate
endmodule

// File: rtl/frt_rr_arb.sv
`timescale 1ns/1ps
// Round-robin arbiter for one output.
// When en is high, the first requester at or after the rotating pointer is granted.
// The pointer then moves to the next position after the winner.
// Assumes: en is high only while the output is unowned.
module frt_rr_arb #(
    parameter int N   = 6,
    localparam int PW = (N > 1) ? $clog2(N) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    logic [PW-1:0] ptr;
    logic [PW-1:0] win;

    // Scan the requests from the pointer and grant the first one found.
    always_comb begin
        logic found;
        int   idx;
        gnt   = '0;
        win   = ptr;
        found = 1'b0;
        for (int k = 0; k < N; k++) begin
            idx = int'(ptr) + k;
            if (idx >= N) idx = idx - N;
            if (en && !found && req[idx]) begin
                gnt[idx] = 1'b1;
                win      = PW'(idx);
                found    = 1'b1;
            end
        end
    end

    // After a grant, give the next position priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (|gnt) begin
            ptr <= (win == PW'(N - 1)) ? '0 : win + PW'(1);
        end
    end
endmodule

// File: rtl/frt_router.sv
`timescale 1ns/1ps
// Fat-tree router node with wormhole switching.
// Ports 0..NUM_CHILD-1 face the children and the remaining ports face the parents.
// Head words descend to the child that their address selects, or climb to the
// lowest-index free parent.
// Each output is owned by one input from its grant until the tail word passes.
// Assumes: packets are well formed (exactly one tail word each), and
// parent-side traffic is addressed inside this node's subtree.
module frt_router import frt_pkg::*; #(
    parameter int CHILD_BITS  = 2,
    parameter int NUM_PARENT  = 2,
    parameter int ADDR_W      = 4,
    parameter int LEVEL       = 0,
    parameter int SUBTREE_ID  = 1,
    parameter int FIFO_DEPTH  = 4,
    localparam int NUM_CHILD  = 1 << CHILD_BITS,
    localparam int NP         = NUM_CHILD + NUM_PARENT,
    localparam int IDX_W      = $clog2(NP),
    localparam int FW         = $bits(flit_t)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NP-1:0]        in_valid,
    output logic [NP-1:0]        in_ready,
    input  logic [NP*FLIT_W-1:0] in_data,
    input  logic [NP-1:0]        in_last,
    output logic [NP-1:0]        out_valid,
    input  logic [NP-1:0]        out_ready,
    output logic [NP*FLIT_W-1:0] out_data,
    output logic [NP-1:0]        out_last
);
    flit_t                      head [NP];
    logic [NP-1:0]              head_vld;
    logic [NP-1:0]              pop;
    logic [NP-1:0]              bound;
    logic [NP-1:0]              go_up;
    logic [NP-1:0]              climb_req;
    logic [NP-1:0]              take;
    logic [CHILD_BITS-1:0]      csel     [NP];
    logic [IDX_W-1:0]           sel      [NP];
    logic [IDX_W-1:0]           take_sel [NP];
    logic [NP-1:0]              arb_req  [NP];
    logic [NP-1:0]              arb_gnt  [NP];
    logic [NP-1:0]              up_left  [NUM_PARENT+1];
    logic [NP-1:0]              own_vld;
    logic [NP-1:0][IDX_W-1:0]   own_idx;
    logic [IDX_W-1:0]           gnt_idx  [NP];

    // ---------------- input side ----------------
    for (genvar i = 0; i < NP; i++) begin : g_in
        frt_in_fifo #(
            .W     (FW),
            .DEPTH (FIFO_DEPTH)
        ) u_fifo (
            .clk        (clk),
            .rst_n      (rst_n),
            .push_valid (in_valid[i]),
            .push_ready (in_ready[i]),
            .push_word  ({in_last[i], in_data[i*FLIT_W +: FLIT_W]}),
            .head_valid (head_vld[i]),
            .head_word  (head[i]),
            .pop        (pop[i])
        );

        frt_route #(
            .ADDR_W      (ADDR_W),
            .CHILD_BITS  (CHILD_BITS),
            .LEVEL       (LEVEL),
            .SUBTREE_ID  (SUBTREE_ID),
            .FROM_PARENT (i >= NUM_CHILD)
        ) u_route (
            .dest  (head[i].data[ADDR_W-1:0]),
            .up    (go_up[i]),
            .child (csel[i])
        );

        // An unbound input with a word at its FIFO front is presenting a head.
        assign climb_req[i] = head_vld[i] && !bound[i] && go_up[i];
        // A bound input moves a word when its granted output is ready.
        assign pop[i] = bound[i] && head_vld[i] && out_ready[sel[i]];
    end

    // Climbing requests feed the parent arbiters in index order.
    assign up_left[0] = climb_req;

    // ---------------- output side ----------------
    for (genvar o = 0; o < NP; o++) begin : g_out
        if (o < NUM_CHILD) begin : g_child
            for (genvar i = 0; i < NP; i++) begin : g_req
                assign arb_req[o][i] = head_vld[i] && !bound[i] && !go_up[i]
                                       && (csel[i] == CHILD_BITS'(o));
            end
        end else begin : g_parent
            // A busy parent takes no request, so climbers pass to the next one.
            assign arb_req[o]                 = own_vld[o] ? '0 : up_left[o-NUM_CHILD];
            assign up_left[o-NUM_CHILD+1]     = up_left[o-NUM_CHILD] & ~arb_gnt[o];
        end

        frt_rr_arb #(
            .N (NP)
        ) u_arb (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (!own_vld[o]),
            .req   (arb_req[o]),
            .gnt   (arb_gnt[o])
        );

        // Convert the one-hot grant to an input index.
        always_comb begin
            gnt_idx[o] = '0;
            for (int i = 0; i < NP; i++) begin
                if (arb_gnt[o][i]) gnt_idx[o] = IDX_W'(i);
            end
        end

        // Hold output ownership from the grant until the tail word is accepted.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                own_vld[o] <= 1'b0;
                own_idx[o] <= '0;
            end else if (!own_vld[o]) begin
                if (|arb_gnt[o]) begin
                    own_vld[o] <= 1'b1;
                    own_idx[o] <= gnt_idx[o];
                end
            end else if (out_valid[o] && out_ready[o] && out_last[o]) begin
                own_vld[o] <= 1'b0;
            end
        end

        // The output shows the front word of the input that owns it.
        assign out_valid[o] = own_vld[o] && head_vld[own_idx[o]];
        assign {out_last[o], out_data[o*FLIT_W +: FLIT_W]} = head[own_idx[o]];
    end

    // Find, for each input, whether an output granted it this cycle, and which one.
    always_comb begin
        for (int i = 0; i < NP; i++) begin
            take[i]     = 1'b0;
            take_sel[i] = '0;
            for (int o = 0; o < NP; o++) begin
                if (arb_gnt[o][i]) begin
                    take[i]     = 1'b1;
                    take_sel[i] = IDX_W'(o);
                end
            end
        end
    end

    // Bind an input to its granted output until its tail word leaves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bound <= '0;
            for (int i = 0; i < NP; i++) sel[i] <= '0;
        end else begin
            for (int i = 0; i < NP; i++) begin
                if (!bound[i]) begin
                    if (take[i]) begin
                        bound[i] <= 1'b1;
                        sel[i]   <= take_sel[i];
                    end
                end else if (pop[i] && head[i].last) begin
                    bound[i] <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/frt_router_chk.sv
`timescale 1ns/1ps
// Property checker for frt_router, attached with bind.
// It watches output ownership and the output handshake.
module frt_router_chk #(
    parameter int NP        = 6,
    parameter int NUM_CHILD = 4,
    parameter int IDX_W     = 3,
    parameter int W         = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NP-1:0]        own_vld,
    input logic [NP-1:0][IDX_W-1:0] own_idx,
    input logic [NP-1:0]        out_valid,
    input logic [NP-1:0]        out_ready,
    input logic [NP*W-1:0]      out_data,
    input logic [NP-1:0]        out_last
);
    logic [NP-1:0] holds [NP];

    for (genvar o = 0; o < NP; o++) begin : g_o
        // R8: a stalled word does not change.
        a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[o] && !out_ready[o] |=>
                out_valid[o] && $stable(out_data[o*W +: W]) && $stable(out_last[o]));

        // R5: the owner stays the same until a tail word is transferred.
        a_r5_owner_kept: assert property (@(posedge clk) disable iff (!rst_n)
            own_vld[o] && !(out_valid[o] && out_ready[o] && out_last[o]) |=>
                own_vld[o] && $stable(own_idx[o]));

        if (o >= NUM_CHILD) begin : g_par
            // R4: traffic from parent inputs never goes back up.
            a_r4_parent_from_child: assert property (@(posedge clk) disable iff (!rst_n)
                own_vld[o] |-> (own_idx[o] < IDX_W'(NUM_CHILD)));
        end

        for (genvar i = 0; i < NP; i++) begin : g_i
            assign holds[i][o] = own_vld[o] && (own_idx[o] == IDX_W'(i));
        end
    end

    for (genvar i = 0; i < NP; i++) begin : g_one
        // R5: an input feeds at most one output at a time.
        a_r5_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(holds[i]));
    end
endmodule

bind frt_router frt_router_chk #(
    .NP        (NP),
    .NUM_CHILD (NUM_CHILD),
    .IDX_W     (IDX_W),
    .W         (frt_pkg::FLIT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .own_vld   (own_vld),
    .own_idx   (own_idx),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last)
);

// File: tb/frt_router_test.sv
`timescale 1ns/1ps
// Bench for frt_router.
// It runs directed corner cases, then random packets under random backpressure.
// Every output word is checked against a model built from the address rules.
module frt_router_test;
    localparam int K   = 4;
    localparam int NP  = 6;
    localparam int W   = 32;
    localparam int SUB = 1;
    localparam int IDS = NP * 256;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [NP-1:0]   in_valid, in_ready, in_last, out_valid, out_last;
    logic [NP-1:0]   out_ready = '0;
    logic [NP*W-1:0] in_data, out_data;

    frt_router uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .in_last   (in_last),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_last  (out_last)
    );

    int vecs = 0, fails = 0;
    logic [W:0] txq [NP][$];
    int  acc_cnt [NP];
    bit  gaps = 1'b0;
    int  rdy_mode = 1;
    int  pkt_len [IDS];
    int  pkt_dest[IDS];
    int  pkt_src [IDS];
    int  seq [NP];
    int  sent = 0, delivered = 0;
    int  order3[$];

    // Record one check and report it if it fails.
    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        vecs++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Outputs allowed for a packet, from the routing rules (R2, R3, R4).
    function automatic logic [NP-1:0] exp_mask(input int src, input int dest);
        if (src >= K || ((dest >> 2) & 3) == SUB) return NP'(1) << (dest & 3);
        return 6'b110000;
    endfunction

    // Build a packet: the header carries the id and the destination, the body carries the id and the word index.
    task automatic send(input int src, input int dest, input int len, output int id);
        logic [W-1:0] d;
        id = src * 256 + seq[src];
        seq[src]++;
        pkt_len[id]  = len;
        pkt_dest[id] = dest;
        pkt_src[id]  = src;
        sent++;
        for (int w = 0; w < len; w++) begin
            d = (w == 0) ? {id[15:0], 12'h000, 4'(dest)} : {id[15:0], 16'(w)};
            txq[src].push_back({(w == len - 1), d});
        end
    endtask

    task automatic wait_drain();
        while (delivered != sent) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // Per-input drivers: present words at the falling edge and hold each one until it is accepted.
    for (genvar g = 0; g < NP; g++) begin : drv
        logic       v;
        logic [W:0] wd;
        bit         r;
        assign in_valid[g]         = v;
        assign in_last[g]          = wd[W];
        assign in_data[g*W +: W]   = wd[W-1:0];
        initial begin
            v = 1'b0;
            wd = '0;
            acc_cnt[g] = 0;
            forever begin
                @(negedge clk);
                if (rst_n && txq[g].size() > 0 && (!gaps || $urandom_range(3) != 0)) begin
                    v  = 1'b1;
                    wd = txq[g][0];
                    r  = in_ready[g];
                    while (!r) begin
                        @(negedge clk);
                        r = in_ready[g];
                    end
                    @(posedge clk);
                    void'(txq[g].pop_front());
                    acc_cnt[g]++;
                end else begin
                    v = 1'b0;
                end
            end
        end
    end

    // Drive out_ready: all ready, all held, or random.
    always @(negedge clk) begin
        case (rdy_mode)
            0:       out_ready = '1;
            1:       out_ready = '0;
            default: out_ready = NP'($urandom) | NP'($urandom);
        endcase
    end

    // Output monitor: checks every transferred word against the packet model.
    bit           busy [NP];
    int           cid  [NP];
    int           cidx [NP];
    logic [W-1:0] md;
    logic [NP-1:0] mk;
    int           hid, hsrc;
    string        lbl;
    always @(negedge clk) begin
        #1;
        for (int o = 0; o < NP; o++) begin
            if (rst_n && out_valid[o] && out_ready[o]) begin
                md = out_data[o*W +: W];
                if (!busy[o]) begin
                    hid = int'(md[31:16]);
                    if (hid >= IDS || pkt_len[hid] == 0) begin
                        chk(1'b0, "R1", "unknown packet header", hid, 0);
                    end else begin
                        hsrc = pkt_src[hid];
                        mk   = exp_mask(hsrc, pkt_dest[hid]);
                        lbl  = (hsrc >= K) ? "R4" : (mk[K] ? "R3" : "R2");
                        chk(mk[o], lbl, "packet on output", o, mk);
                        chk(md[3:0] == 4'(pkt_dest[hid]), "R1", "header address", md[3:0], pkt_dest[hid]);
                        chk(out_last[o] == (pkt_len[hid] == 1), "R10", "tail flag on header",
                            out_last[o], pkt_len[hid] == 1);
                        if (o == 3) order3.push_back(hsrc);
                        if (out_last[o]) begin
                            delivered++;
                        end else begin
                            busy[o] = 1'b1;
                            cid[o]  = hid;
                            cidx[o] = 1;
                        end
                    end
                end else begin
                    chk(md == {16'(cid[o]), 16'(cidx[o])}, "R5", "body word",
                        md, {16'(cid[o]), 16'(cidx[o])});
                    chk(out_last[o] == (cidx[o] == pkt_len[cid[o]] - 1), "R10", "tail flag",
                        out_last[o], cidx[o] == pkt_len[cid[o]] - 1);
                    if (out_last[o]) begin
                        busy[o] = 1'b0;
                        delivered++;
                    end else begin
                        cidx[o]++;
                    end
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        vecs++;
        fails++;
        $display("FAIL watchdog: actual %0d delivered expected %0d", delivered, sent);
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    initial begin
        int ida, idb, idc, idp, tmp;
        logic [W-1:0] hdr;
        void'($urandom(32'd4242));
        for (int s = 0; s < NP; s++) seq[s] = 0;
        rdy_mode = 1;
        repeat (4) @(negedge clk);
        #1;
        // R9: state while reset is held.
        chk(out_valid == '0, "R9", "out_valid in reset", out_valid, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(out_valid == '0, "R9", "out_valid after reset", out_valid, 0);
        chk(in_ready == '1, "R9", "in_ready after reset", in_ready, 6'h3f);

        // R7 / R8: fill input 0 while every output is held.
        send(0, 5, 8, ida);
        repeat (12) @(negedge clk);
        #1;
        hdr = {ida[15:0], 12'h000, 4'h5};
        chk(acc_cnt[0] == 4, "R7", "words accepted with outputs held", acc_cnt[0], 4);
        chk(in_ready[0] == 1'b0, "R7", "in_ready when full", in_ready[0], 0);
        chk(out_valid[1] && out_data[1*W +: W] == hdr, "R8", "stalled header on child 1",
            out_data[1*W +: W], hdr);
        repeat (3) @(negedge clk);
        #1;
        chk(out_valid[1] && out_data[1*W +: W] == hdr, "R8", "header still held",
            out_data[1*W +: W], hdr);
        rdy_mode = 0;
        wait_drain();
        chk(acc_cnt[0] == 8, "R7", "all words accepted after drain", acc_cnt[0], 8);

        // R3 / R11: climbing packets take the lowest free parent; a third one waits.
        rdy_mode = 1;
        repeat (2) @(negedge clk);
        send(0, 12, 3, ida);
        repeat (6) @(negedge clk);
        #1;
        chk(out_valid[4] && out_data[4*W+16 +: 16] == 16'(ida), "R3", "first climber on parent 0",
            out_data[4*W+16 +: 16], ida);
        send(1, 0, 2, idb);
        repeat (6) @(negedge clk);
        #1;
        chk(out_valid[5] && out_data[5*W+16 +: 16] == 16'(idb), "R3", "second climber on parent 1",
            out_data[5*W+16 +: 16], idb);
        send(2, 9, 1, idc);
        repeat (6) @(negedge clk);
        #1;
        chk(out_valid[3:0] == '0, "R11", "waiting climber on no child output", out_valid[3:0], 0);
        chk(out_data[4*W+16 +: 16] == 16'(ida) && out_data[5*W+16 +: 16] == 16'(idb), "R11",
            "parents keep their packets", out_data[4*W+16 +: 16], ida);
        rdy_mode = 0;
        wait_drain();

        // R4: a parent input addressed inside the subtree descends.
        rdy_mode = 1;
        repeat (2) @(negedge clk);
        send(5, 4, 2, idp);
        repeat (6) @(negedge clk);
        #1;
        chk(out_valid[0] && out_data[16 +: 16] == 16'(idp), "R4", "parent input to child 0",
            out_data[16 +: 16], idp);
        chk(out_valid[5:4] == '0, "R4", "nothing on parents", out_valid[5:4], 0);
        rdy_mode = 0;
        wait_drain();

        // R6: two inputs contend for child 3 with single-word packets.
        rdy_mode = 1;
        repeat (2) @(negedge clk);
        order3.delete();
        send(0, 7, 1, tmp);
        send(0, 7, 1, tmp);
        send(1, 7, 1, tmp);
        send(1, 7, 1, tmp);
        repeat (10) @(negedge clk);
        rdy_mode = 0;
        wait_drain();
        chk(order3.size() == 4, "R6", "packets seen on child 3", order3.size(), 4);
        for (int k = 1; k < 4 && k < order3.size(); k++) begin
            chk(order3[k] != order3[k-1], "R6", "sources alternate", order3[k], 1 - order3[k-1]);
        end

        // Random traffic with random gaps and backpressure (R1, R2, R3, R4, R5, R10).
        gaps     = 1'b1;
        rdy_mode = 2;
        for (int n = 0; n < 240; n++) begin
            int s, d, l;
            s = $urandom_range(NP - 1);
            d = (s >= K) ? (SUB * 4 + $urandom_range(3)) : $urandom_range(15);
            l = 1 + $urandom_range(5);
            send(s, d, l, tmp);
            if ($urandom_range(3) == 0) @(negedge clk);
        end
        wait_drain();
        chk(delivered == sent, "R1", "packets delivered", delivered, sent);

        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end
endmodule